// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 64 level-sensitive interrupt requests and presents them to a processor on two outputs: a normal request line and a fast request line. Software programs it through a 32-bit register bus with separate read and write strobes. Per-source enable, type and force bits are held in pairs of 32-bit words. Each source also has a 4-bit priority, packed eight to a register. A 5-bit threshold masks normal requests whose priority is too low.

Two vector/status registers tell the interrupt handler which source to service. The normal one names the pending normal source with the highest priority, and the fast one names the lowest-numbered pending fast source. Enables can be written as whole words, or changed one at a time by writing a source number to a set-by-number or clear-by-number address. That way a handler masks or unmasks one source without a read-modify-write.

Top module: `irqVecCtl`

## Requirements
- R1: After reset, the enable, type, force, priority and control registers read 0, the threshold reads 0x1F, both request outputs are low, and both vector registers read 0xFFFF0000.
- R2: Writing N (0 to 63) to address 0x08 sets enable bit N, and writing N to address 0x0C clears it; no other enable bit changes, and written values of 64 or more change nothing.
- R3: Sources 0 to 31 live at bit N in the low word and sources 32 to 63 at bit N-32 in the high word of each pair: enable 0x14/0x10, type 0x1C/0x18, raw input 0x4C/0x48, force 0x54/0x50, normal pending 0x5C/0x58, fast pending 0x64/0x60 (low/high).
- R4: The priority of source N is the nibble at bits 4*(N mod 8)+3 down to 4*(N mod 8) of the register at 0x20 + 4*(7 - N/8); these registers read back what was written.
- R5: A source is active when (raw input OR force bit) AND enable bit. An active source with type bit 1 is fast pending. An active source with type bit 0 is normal pending only if its priority is greater than the threshold, so a threshold of 16 or more masks all normal sources.
- R6: Address 0x40 reads the pending normal source with the highest priority in bits 31:16 and its priority in bits 15:0. Ties go to the higher source number. With nothing pending it reads 0xFFFF0000.
- R7: Address 0x44 reads the lowest-numbered fast pending source in bits 31:16 with bits 15:0 zero, or 0xFFFF0000 when none is pending.
- R8: irqNorm and irqFast are registered: each goes high or low on the first clock edge after any normal or fast source, respectively, becomes or stops being pending.
- R9: Writes to read-only addresses (0x40 to 0x4C, 0x58 to 0x64) change nothing. Reads of unused or write-only addresses (0x08, 0x0C, above 0x64, or not word aligned) return 0, and busRdata is 0 while busRd is low.
- R10: The control word at 0x00 holds all 32 written bits. The threshold at 0x04 keeps the low 5 bits written and reads 0 in bits 31:5.
- R11: Requests are level-sensitive: a pending bit and the output it drives fall once the source input falls, with no latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address of the register access |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRd | input | 1 | Read strobe |
| busRdata | output | 32 | Read data, valid combinationally while busRd is high |
| srcIn | input | 64 | Level-sensitive interrupt request inputs |
| irqNorm | output | 1 | Registered normal interrupt request |
| irqFast | output | 1 | Registered fast interrupt request |

## Verification
The assertions assume a write strobe lasts exactly one cycle with a stable address and data, and that srcIn is synchronous to clk. The bench changes every input at the falling edge and pulses busWr for a single cycle per access, so both conditions hold. The number-write assertions further assume that only the two number addresses touch the enable word in the cycle being checked. The bench never issues another write in that cycle.

// File: rtl/irqVecCtlPkg.sv
package irqVecCtlPkg;

  typedef enum logic [4:0] {
    RS_NONE, RS_CTL, RS_THR, RS_ENH, RS_ENL, RS_TYH, RS_TYL, RS_PRIO,
    RS_NVEC, RS_FVEC, RS_SRCH, RS_SRCL, RS_FRCH, RS_FRCL,
    RS_NPH, RS_NPL, RS_FPH, RS_FPL
  } rdSel_e;

  typedef struct packed {
    logic   wrCtl;
    logic   wrThr;
    logic   wrEnNum;
    logic   wrDisNum;
    logic   wrEnH;
    logic   wrEnL;
    logic   wrTypH;
    logic   wrTypL;
    logic   wrFrcH;
    logic   wrFrcL;
    logic   wrPrio;
    logic [2:0] prioGrp;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/irqVecCtlDecode.sv
module irqVecCtlDecode
  import irqVecCtlPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output strobes_t          stb
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wIdx;
  logic             aligned;

  assign wIdx    = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    stb = '0;
    stb.rdSel = RS_NONE;
    stb.prioGrp = ~wIdx[2:0];
    if (aligned) begin
      unique case (wIdx)
        IDX_W'(0):  begin stb.wrCtl   = busWr; stb.rdSel = RS_CTL;  end
        IDX_W'(1):  begin stb.wrThr   = busWr; stb.rdSel = RS_THR;  end
        IDX_W'(2):  stb.wrEnNum  = busWr;
        IDX_W'(3):  stb.wrDisNum = busWr;
        IDX_W'(4):  begin stb.wrEnH  = busWr; stb.rdSel = RS_ENH; end
        IDX_W'(5):  begin stb.wrEnL  = busWr; stb.rdSel = RS_ENL; end
        IDX_W'(6):  begin stb.wrTypH = busWr; stb.rdSel = RS_TYH; end
        IDX_W'(7):  begin stb.wrTypL = busWr; stb.rdSel = RS_TYL; end
        IDX_W'(8), IDX_W'(9), IDX_W'(10), IDX_W'(11),
        IDX_W'(12), IDX_W'(13), IDX_W'(14), IDX_W'(15):
                    begin stb.wrPrio = busWr; stb.rdSel = RS_PRIO; end
        IDX_W'(16): stb.rdSel = RS_NVEC;
        IDX_W'(17): stb.rdSel = RS_FVEC;
        IDX_W'(18): stb.rdSel = RS_SRCH;
        IDX_W'(19): stb.rdSel = RS_SRCL;
        IDX_W'(20): begin stb.wrFrcH = busWr; stb.rdSel = RS_FRCH; end
        IDX_W'(21): begin stb.wrFrcL = busWr; stb.rdSel = RS_FRCL; end
        IDX_W'(22): stb.rdSel = RS_NPH;
        IDX_W'(23): stb.rdSel = RS_NPL;
        IDX_W'(24): stb.rdSel = RS_FPH;
        IDX_W'(25): stb.rdSel = RS_FPL;
        default:    stb.rdSel = RS_NONE;
      endcase
    end
    if (!busRd) stb.rdSel = RS_NONE;
  end

endmodule

// File: rtl/irqVecCtlCore.sv
module irqVecCtlCore
  import irqVecCtlPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PRIO_W = 4,
  parameter int THR_W  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            stb,
  input  logic [WORD_W-1:0]   busWdata,
  input  logic [2*WORD_W-1:0] srcIn,
  output logic [WORD_W-1:0]   busRdata,
  output logic                irqNorm,
  output logic                irqFast
);
  localparam int NUM_SRC = 2 * WORD_W;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int HALF_W  = WORD_W / 2;
  localparam int PER_GRP = WORD_W / PRIO_W;
  localparam int NUM_GRP = NUM_SRC / PER_GRP;
  localparam int GRP_W   = $clog2(NUM_GRP);

  logic [WORD_W-1:0]              ctlReg;
  logic [THR_W-1:0]               thrReg;
  logic [NUM_SRC-1:0]             enReg, typReg, frcReg;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prioReg;

  logic [NUM_SRC-1:0] activeVec, normPend, fastPend;
  logic               nFound, fFound;
  logic [IDX_W-1:0]   nNum, fNum;
  logic [PRIO_W-1:0]  nPrio;
  logic [WORD_W-1:0]  nVec, fVec, prioWord;
  logic               numOk;
  logic [GRP_W-1:0]   grp;

  assign numOk = (busWdata < WORD_W'(NUM_SRC));
  assign grp   = GRP_W'(stb.prioGrp);

  // register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg  <= '0;
      thrReg  <= '1;
      enReg   <= '0;
      typReg  <= '0;
      frcReg  <= '0;
      prioReg <= '0;
    end else begin
      if (stb.wrCtl)  ctlReg <= busWdata;
      if (stb.wrThr)  thrReg <= busWdata[THR_W-1:0];
      if (stb.wrEnH)  enReg[NUM_SRC-1:WORD_W]  <= busWdata;
      if (stb.wrEnL)  enReg[WORD_W-1:0]        <= busWdata;
      if (stb.wrTypH) typReg[NUM_SRC-1:WORD_W] <= busWdata;
      if (stb.wrTypL) typReg[WORD_W-1:0]       <= busWdata;
      if (stb.wrFrcH) frcReg[NUM_SRC-1:WORD_W] <= busWdata;
      if (stb.wrFrcL) frcReg[WORD_W-1:0]       <= busWdata;
      if (stb.wrEnNum && numOk)  enReg[busWdata[IDX_W-1:0]] <= 1'b1;
      if (stb.wrDisNum && numOk) enReg[busWdata[IDX_W-1:0]] <= 1'b0;
      if (stb.wrPrio) begin
        for (int k = 0; k < PER_GRP; k++)
          prioReg[int'(grp)*PER_GRP + k] <= busWdata[k*PRIO_W +: PRIO_W];
      end
    end
  end

  // pending evaluation per source
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
    assign activeVec[i] = (srcIn[i] | frcReg[i]) & enReg[i];
    assign fastPend[i]  = activeVec[i] & typReg[i];
    assign normPend[i]  = activeVec[i] & ~typReg[i] &
                          ({1'b0, prioReg[i]} > thrReg);
  end

  // normal arbitration: highest priority, ties to higher number
  always_comb begin
    nFound = 1'b0;
    nNum   = '0;
    nPrio  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (normPend[i] && (!nFound || prioReg[i] >= nPrio)) begin
        nFound = 1'b1;
        nNum   = IDX_W'(i);
        nPrio  = prioReg[i];
      end
    end
  end

  // fast arbitration: lowest number wins
  always_comb begin
    fFound = 1'b0;
    fNum   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (fastPend[i]) begin
        fFound = 1'b1;
        fNum   = IDX_W'(i);
      end
    end
  end

  assign nVec = nFound ? {HALF_W'(nNum), HALF_W'(nPrio)} : {{HALF_W{1'b1}}, HALF_W'(0)};
  assign fVec = fFound ? {HALF_W'(fNum), HALF_W'(0)}     : {{HALF_W{1'b1}}, HALF_W'(0)};

  always_comb begin
    prioWord = '0;
    for (int k = 0; k < PER_GRP; k++)
      prioWord[k*PRIO_W +: PRIO_W] = prioReg[int'(grp)*PER_GRP + k];
  end

  always_comb begin
    unique case (stb.rdSel)
      RS_CTL:  busRdata = ctlReg;
      RS_THR:  busRdata = WORD_W'(thrReg);
      RS_ENH:  busRdata = enReg[NUM_SRC-1:WORD_W];
      RS_ENL:  busRdata = enReg[WORD_W-1:0];
      RS_TYH:  busRdata = typReg[NUM_SRC-1:WORD_W];
      RS_TYL:  busRdata = typReg[WORD_W-1:0];
      RS_PRIO: busRdata = prioWord;
      RS_NVEC: busRdata = nVec;
      RS_FVEC: busRdata = fVec;
      RS_SRCH: busRdata = srcIn[NUM_SRC-1:WORD_W];
      RS_SRCL: busRdata = srcIn[WORD_W-1:0];
      RS_FRCH: busRdata = frcReg[NUM_SRC-1:WORD_W];
      RS_FRCL: busRdata = frcReg[WORD_W-1:0];
      RS_NPH:  busRdata = normPend[NUM_SRC-1:WORD_W];
      RS_NPL:  busRdata = normPend[WORD_W-1:0];
      RS_FPH:  busRdata = fastPend[NUM_SRC-1:WORD_W];
      RS_FPL:  busRdata = fastPend[WORD_W-1:0];
      default: busRdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqNorm <= 1'b0;
      irqFast <= 1'b0;
    end else begin
      irqNorm <= |normPend;
      irqFast <= |fastPend;
    end
  end

endmodule

// File: rtl/irqVecCtl.sv
module irqVecCtl
  import irqVecCtlPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic [WORD_W-1:0]   busWdata,
  input  logic                busRd,
  output logic [WORD_W-1:0]   busRdata,
  input  logic [2*WORD_W-1:0] srcIn,
  output logic                irqNorm,
  output logic                irqFast
);
  strobes_t stb;

  irqVecCtlDecode #(.ADDR_W(ADDR_W)) decodeU (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .stb     (stb)
  );

  irqVecCtlCore #(.WORD_W(WORD_W)) coreU (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .srcIn    (srcIn),
    .busRdata (busRdata),
    .irqNorm  (irqNorm),
    .irqFast  (irqFast)
  );

endmodule

// File: rtl/irqVecCtlChk.sv
module irqVecCtlChk #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWr,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [WORD_W-1:0]   busWdata,
  input logic                irqNorm,
  input logic                irqFast,
  input logic [2*WORD_W-1:0] enReg,
  input logic [2*WORD_W-1:0] typReg,
  input logic [4:0]          thrReg
);
  localparam int NUM_SRC = 2 * WORD_W;
  localparam int IDX_W   = $clog2(NUM_SRC);

  logic setNum, clrNum;
  assign setNum = busWr && (busAddr == ADDR_W'(8'h08)) && (busWdata < WORD_W'(NUM_SRC));
  assign clrNum = busWr && (busAddr == ADDR_W'(8'h0C)) && (busWdata < WORD_W'(NUM_SRC));

  AST_ENNUM_SETS: assert property (@(posedge clk) disable iff (!rstN)
    setNum |=> enReg[$past(busWdata[IDX_W-1:0])]); // R2

  AST_DISNUM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    clrNum |=> !enReg[$past(busWdata[IDX_W-1:0])]); // R2

  AST_NUM_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (busAddr == ADDR_W'(8'h08) || busAddr == ADDR_W'(8'h0C)))
      |=> ($countones(enReg ^ $past(enReg)) <= 1)); // R2

  AST_FAST_NEEDS_TYPE: assert property (@(posedge clk) disable iff (!rstN)
    irqFast |-> $past(|(typReg & enReg))); // R5

  AST_THR_MASKS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (thrReg >= 5'd16) |=> !irqNorm); // R5

endmodule

bind irqVecCtl irqVecCtlChk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) chkU (
  .clk      (clk),
  .rstN     (rstN),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .irqNorm  (irqNorm),
  .irqFast  (irqFast),
  .enReg    (coreU.enReg),
  .typReg   (coreU.typReg),
  .thrReg   (coreU.thrReg)
);

// File: tb/irqVecCtl_test.sv
module irqVecCtl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRd = 1'b0;
  logic [31:0] busRdata;
  logic [63:0] srcIn = '0;
  logic        irqNorm, irqFast;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  irqVecCtl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRd(busRd), .busRdata(busRdata),
    .srcIn(srcIn), .irqNorm(irqNorm), .irqFast(irqFast)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1;
    check(req, busRdata, exp);
    busRd = 1'b0;
  endtask

  task automatic clearAll();
    wr(8'h10, 0); wr(8'h14, 0); wr(8'h18, 0); wr(8'h1C, 0);
    wr(8'h50, 0); wr(8'h54, 0); wr(8'h04, 0);
    for (int g = 0; g < 8; g++) wr(8'h20 + 8'(4*g), 0);
    srcIn = '0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 irqNorm", {31'b0, irqNorm}, 0);
    check("R1 irqFast", {31'b0, irqFast}, 0);
    rdChk("R1 ctl", 8'h00, 0);
    rdChk("R1 thr", 8'h04, 32'h1F);
    rdChk("R1 enH", 8'h10, 0);
    rdChk("R1 enL", 8'h14, 0);
    rdChk("R1 typL", 8'h1C, 0);
    rdChk("R1 prio g0", 8'h3C, 0);
    rdChk("R1 nvec", 8'h40, 32'hFFFF0000);
    rdChk("R1 fvec", 8'h44, 32'hFFFF0000);
  endtask

  task automatic testEnNum();
    wr(8'h08, 5); wr(8'h08, 40);
    rdChk("R2 R3 enL after set 5", 8'h14, 32'h20);
    rdChk("R2 R3 enH after set 40", 8'h10, 32'h100);
    wr(8'h0C, 5);
    rdChk("R2 enL after clear 5", 8'h14, 0);
    rdChk("R2 enH untouched", 8'h10, 32'h100);
    wr(8'h08, 64); wr(8'h0C, 32'h128);
    rdChk("R2 out of range ignored L", 8'h14, 0);
    rdChk("R2 out of range ignored H", 8'h10, 32'h100);
    wr(8'h0C, 40);
    rdChk("R2 enH after clear 40", 8'h10, 0);
  endtask

  task automatic testPrio();
    wr(8'h20, 32'h76543210);
    wr(8'h3C, 32'hA0B0C0D0);
    rdChk("R4 group7 readback", 8'h20, 32'h76543210);
    rdChk("R4 group0 readback", 8'h3C, 32'hA0B0C0D0);
    rdChk("R4 group3 untouched", 8'h30, 0);
  endtask

  task automatic testNormArb();
    clearAll();
    wr(8'h3C, 32'h00005000);   // source 3 prio 5
    wr(8'h20, 32'h00050000);   // source 60 prio 5
    wr(8'h38, 32'h00000200);   // source 10 prio 2
    wr(8'h08, 3); wr(8'h08, 10); wr(8'h08, 60);
    @(negedge clk);
    srcIn[3] = 1'b1; srcIn[10] = 1'b1; srcIn[60] = 1'b1;
    rdChk("R6 tie to higher number", 8'h40, {16'd60, 16'd5});
    rdChk("R3 R5 normal pending low", 8'h5C, 32'h408);
    rdChk("R3 R5 normal pending high", 8'h58, 32'h10000000);
    rdChk("R3 raw low", 8'h4C, 32'h408);
    @(negedge clk); srcIn[60] = 1'b0;
    rdChk("R6 R11 after source 60 drops", 8'h40, {16'd3, 16'd5});
    @(negedge clk); srcIn[3] = 1'b0;
    rdChk("R6 lower priority wins alone", 8'h40, {16'd10, 16'd2});
    wr(8'h04, 2);
    rdChk("R5 prio equal to threshold masked", 8'h40, 32'hFFFF0000);
    wr(8'h04, 1);
    rdChk("R5 prio above threshold passes", 8'h40, {16'd10, 16'd2});
    wr(8'h3C, 32'hF0000000);   // source 7 prio 15
    wr(8'h08, 7);
    @(negedge clk); srcIn[7] = 1'b1;
    rdChk("R6 highest priority wins", 8'h40, {16'd7, 16'd15});
    wr(8'h04, 16);
    rdChk("R5 threshold 16 masks prio 15", 8'h40, 32'hFFFF0000);
    @(negedge clk); @(negedge clk);
    check("R5 irqNorm masked", {31'b0, irqNorm}, 0);
  endtask

  task automatic testFast();
    clearAll();
    wr(8'h1C, 32'h00100080);   // sources 7 and 20 fast
    wr(8'h18, 32'h2);          // source 33 fast
    wr(8'h08, 7); wr(8'h08, 20); wr(8'h08, 33);
    wr(8'h54, 32'h00100080);
    wr(8'h50, 32'h2);
    rdChk("R7 lowest fast wins", 8'h44, {16'd7, 16'd0});
    rdChk("R3 R5 fast pending low", 8'h64, 32'h00100080);
    rdChk("R3 R5 fast pending high", 8'h60, 32'h2);
    rdChk("R5 fast not normal", 8'h5C, 0);
    rdChk("R5 no normal vector", 8'h40, 32'hFFFF0000);
    wr(8'h54, 32'h00100000);
    rdChk("R7 next fast after force clear", 8'h44, {16'd20, 16'd0});
    check("R8 irqFast set", {31'b0, irqFast}, 1);
    check("R8 irqNorm clear", {31'b0, irqNorm}, 0);
    wr(8'h54, 0); wr(8'h50, 0);
    rdChk("R7 none pending", 8'h44, 32'hFFFF0000);
  endtask

  task automatic testLatency();
    clearAll();
    wr(8'h38, 32'h00030000);   // source 12 prio 3
    wr(8'h08, 12);
    @(negedge clk);
    srcIn[12] = 1'b1;
    #1;
    check("R8 irqNorm not before edge", {31'b0, irqNorm}, 0);
    @(negedge clk);
    check("R8 irqNorm one edge later", {31'b0, irqNorm}, 1);
    srcIn[12] = 1'b0;
    #1;
    check("R8 irqNorm holds until edge", {31'b0, irqNorm}, 1);
    @(negedge clk);
    check("R11 irqNorm falls with level", {31'b0, irqNorm}, 0);
  endtask

  task automatic testReadOnly();
    clearAll();
    @(negedge clk); srcIn = 64'h0000_0001_8000_0004;
    wr(8'h40, 32'h12345678); wr(8'h4C, 32'hFFFFFFFF);
    wr(8'h48, 32'hFFFFFFFF); wr(8'h5C, 32'hFFFFFFFF); wr(8'h64, 32'hFFFFFFFF);
    rdChk("R9 raw low unchanged", 8'h4C, 32'h80000004);
    rdChk("R9 raw high unchanged", 8'h48, 32'h1);
    rdChk("R9 vector unchanged", 8'h40, 32'hFFFF0000);
    rdChk("R9 enable unchanged", 8'h14, 0);
    rdChk("R9 unused 0x68", 8'h68, 0);
    rdChk("R9 write-only 0x08", 8'h08, 0);
    rdChk("R9 unaligned", 8'h15, 0);
    @(negedge clk); busAddr = 8'h4C; busRd = 1'b0; #1;
    check("R9 rdata zero without strobe", busRdata, 0);
    srcIn = '0;
  endtask

  task automatic testCtl();
    wr(8'h00, 32'hDEADBEEF);
    rdChk("R10 control readback", 8'h00, 32'hDEADBEEF);
    wr(8'h04, 32'hFFFFFFFF);
    rdChk("R10 threshold width", 8'h04, 32'h1F);
  endtask

  initial begin
    #(4 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEnNum();
    testPrio();
    testNormArb();
    testFast();
    testLatency();
    testReadOnly();
    testCtl();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule